// File: doc/BRIEF.md
# Security session state tracker

This block keeps the security privileges of one host session on a secure memory device. A command engine elsewhere on the chip runs the cryptographic checks and delivers the results to this block as one-cycle pulses. The pulses cover password verification, authentication, encryption activation, MAC mismatch, the external reset pin and power-on. From these the block keeps the session mode, the single remembered password grant and the authenticated key set. It also keeps one consecutive-failure counter for each password set and one for each key set. A set whose counter has reached the trial limit is locked out.

The mode climbs a three-step ladder: standard, then authenticated, then encrypted. Only the most recent password and the most recent authentication are remembered. A failed attempt or a MAC mismatch takes away privileges the session already held. All outputs are registered and change on the clock edge that samples the event. Pulses of the same cycle follow a fixed priority. The reset pin overrides everything. A MAC mismatch abandons every other event of its cycle. Within one kind of attempt, fail wins over pass. An authentication attempt suppresses an encryption activation in the same cycle.

Top module: `sec_session_guard`

## Requirements
- R1: While the power-on reset `rst_n` is low, mode is standard (`mode_o`=2'b00), read and write grants are 0, `pw_set_o`=0, `key_o`=0 and every lock flag is 0. This includes locks gained before the reset.
- R2: A successful password verification grants read. It grants write as well when `pw_write_i`=1. It records `pw_set_i` in `pw_set_o`. It replaces any earlier grant, so only the latest set is held.
- R3: A failed password attempt clears the read and write grants and sets `pw_set_o` to 0. A pass on a locked set counts as a failed attempt.
- R4: A successful authentication sets mode to authenticated (2'b01) from any mode and records `auth_key_i` in `key_o`.
- R5: A failed authentication attempt sets mode to standard and `key_o` to 0. A pass on a locked key set counts as a failed attempt.
- R6: An encryption activation sets mode to encrypted (2'b10) only when the mode is authenticated or encrypted. In standard mode it changes nothing.
- R7: A MAC mismatch sets mode to standard and `key_o` to 0. It leaves the password grant and all failure counters unchanged, and it abandons every other event in its cycle.
- R8: The reset pin sets mode to standard and clears the password grant and `key_o`. It keeps the failure counters and lock flags, and it abandons every other event in its cycle.
- R9: Each password set and each key set has its own count of consecutive failed attempts. A success on that set clears the count. The lock flag of a set (bit i of `pw_lock_o` / `key_lock_o`) rises when the count reaches `TRIAL_LIMIT`.
- R10: A lock flag stays set until power-on reset. While a set is locked, its passes never grant privileges.
- R11: Pass and fail of the same kind in one cycle act as a fail. An authentication attempt in the same cycle as an encryption activation ignores the activation.
- R12: Outputs change only on the clock edge that samples the event, one cycle after it is presented, and never before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_i | input | 1 | External reset pin asserted (pulse) |
| pw_pass_i | input | 1 | Password verification passed |
| pw_fail_i | input | 1 | Password verification failed |
| pw_set_i | input | 3 | Password set of the attempt |
| pw_write_i | input | 1 | 1: write password, 0: read password |
| auth_pass_i | input | 1 | Authentication passed |
| auth_fail_i | input | 1 | Authentication failed |
| auth_key_i | input | 2 | Key set of the authentication attempt |
| enc_activate_i | input | 1 | Encryption activation request succeeded |
| mac_fail_i | input | 1 | MAC mismatch on incoming command |
| mode_o | output | 2 | 00 standard, 01 authenticated, 10 encrypted |
| pw_read_o | output | 1 | Read grant of the active password set |
| pw_write_o | output | 1 | Write grant of the active password set |
| pw_set_o | output | 3 | Active password set |
| key_o | output | 2 | Authenticated key set |
| pw_lock_o | output | 8 | Lockout flag for each password set |
| key_lock_o | output | 4 | Lockout flag for each key set |

## Verification
The bench keeps the default eight password sets and four key sets, so the highest index of each bank is exercised. It lowers `TRIAL_LIMIT` to 2, so a lockout, a count cleared by success, and a lock that survives the reset pin but not power-on all fit in a few pulses. Every clock is compared against a behavioural model. Directed cases cover same-cycle collisions of pass with fail, authentication with activation, and MAC mismatch with everything else.

// File: rtl/sess_pkg.sv
package sess_pkg;

  typedef enum logic [1:0] {
    SESS_STD  = 2'b00,
    SESS_AUTH = 2'b01,
    SESS_ENC  = 2'b10
  } sess_mode_e;

  localparam int TRIAL_CW = 3;

  // An attempt counts as success only if it passed, did not also fail,
  // and its set is not locked out.
  function automatic logic attempt_ok(input logic pass, input logic fail,
                                      input logic locked);
    return pass & ~fail & ~locked;
  endfunction

  // Saturating consecutive-failure count, cleared by a success.
  function automatic logic [TRIAL_CW-1:0] trial_next(
      input logic [TRIAL_CW-1:0] cnt, input logic ok, input int limit);
    if (ok) return '0;
    if (int'(cnt) >= limit) return cnt;
    return cnt + 1'b1;
  endfunction

  function automatic logic trial_locked(input logic [TRIAL_CW-1:0] cnt,
                                        input int limit);
    return int'(cnt) >= limit;
  endfunction

endpackage

// File: rtl/sess_trial_bank.sv
module sess_trial_bank #(
  parameter int N_SETS = 8,
  parameter int LIMIT  = 3,
  localparam int IW    = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              ok_i,
  input  logic [IW-1:0]     idx_i,
  output logic [N_SETS-1:0] lock_o
);
  import sess_pkg::*;

  for (genvar g = 0; g < N_SETS; g++) begin : g_set
    localparam logic [IW-1:0] MY_IDX = IW'(g);
    logic [TRIAL_CW-1:0] cnt_q;
    logic                sel_w;

    assign sel_w = hit_i && (idx_i == MY_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (sel_w) begin
        cnt_q <= trial_next(cnt_q, ok_i, LIMIT);
      end
    end

    assign lock_o[g] = trial_locked(cnt_q, LIMIT);
  end

endmodule

// File: rtl/sess_pw_grant.sv
module sess_pw_grant #(
  parameter int N_SETS = 8,
  localparam int IW    = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          ok_i,
  input  logic          bad_i,
  input  logic [IW-1:0] set_i,
  input  logic          wr_i,
  output logic          read_o,
  output logic          write_o,
  output logic [IW-1:0] set_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_o  <= 1'b0;
      write_o <= 1'b0;
      set_o   <= '0;
    end else if (clr_i || bad_i) begin
      read_o  <= 1'b0;
      write_o <= 1'b0;
      set_o   <= '0;
    end else if (ok_i) begin
      read_o  <= 1'b1;
      write_o <= wr_i;
      set_o   <= set_i;
    end
  end

endmodule

// File: rtl/sess_auth_mode.sv
module sess_auth_mode #(
  parameter int N_KEYS = 4,
  localparam int KW    = (N_KEYS > 1) ? $clog2(N_KEYS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 ok_i,
  input  logic                 bad_i,
  input  logic [KW-1:0]        key_i,
  input  logic                 enc_ok_i,
  output sess_pkg::sess_mode_e mode_o,
  output logic [KW-1:0]        key_o
);
  import sess_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= SESS_STD;
      key_o  <= '0;
    end else if (clr_i || bad_i) begin
      mode_o <= SESS_STD;
      key_o  <= '0;
    end else if (ok_i) begin
      mode_o <= SESS_AUTH;
      key_o  <= key_i;
    end else if (enc_ok_i) begin
      mode_o <= SESS_ENC;
    end
  end

endmodule

// File: rtl/sec_session_guard.sv
module sec_session_guard #(
  parameter int N_PW_SETS   = 8,
  parameter int N_KEY_SETS  = 4,
  parameter int TRIAL_LIMIT = 3,
  localparam int PW_IW      = (N_PW_SETS > 1) ? $clog2(N_PW_SETS) : 1,
  localparam int KEY_IW     = (N_KEY_SETS > 1) ? $clog2(N_KEY_SETS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rst_pin_i,
  input  logic                  pw_pass_i,
  input  logic                  pw_fail_i,
  input  logic [PW_IW-1:0]      pw_set_i,
  input  logic                  pw_write_i,
  input  logic                  auth_pass_i,
  input  logic                  auth_fail_i,
  input  logic [KEY_IW-1:0]     auth_key_i,
  input  logic                  enc_activate_i,
  input  logic                  mac_fail_i,
  output logic [1:0]            mode_o,
  output logic                  pw_read_o,
  output logic                  pw_write_o,
  output logic [PW_IW-1:0]      pw_set_o,
  output logic [KEY_IW-1:0]     key_o,
  output logic [N_PW_SETS-1:0]  pw_lock_o,
  output logic [N_KEY_SETS-1:0] key_lock_o
);
  import sess_pkg::*;

  // Named internal events, also observed by the checker.
  logic       abandon_w;
  logic       pw_try_w, pw_ok_w, pw_bad_w;
  logic       au_try_w, au_ok_w, au_bad_w;
  logic       enc_ok_w;
  sess_mode_e mode_q;

  assign abandon_w = rst_pin_i | mac_fail_i;

  assign pw_try_w = (pw_pass_i | pw_fail_i) & ~abandon_w;
  assign pw_ok_w  = pw_try_w & attempt_ok(pw_pass_i, pw_fail_i, pw_lock_o[pw_set_i]);
  assign pw_bad_w = pw_try_w & ~pw_ok_w;

  assign au_try_w = (auth_pass_i | auth_fail_i) & ~abandon_w;
  assign au_ok_w  = au_try_w & attempt_ok(auth_pass_i, auth_fail_i, key_lock_o[auth_key_i]);
  assign au_bad_w = au_try_w & ~au_ok_w;

  assign enc_ok_w = enc_activate_i & ~abandon_w & ~au_try_w & (mode_q != SESS_STD);

  sess_trial_bank #(.N_SETS(N_PW_SETS), .LIMIT(TRIAL_LIMIT)) u_pw_trials (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (pw_try_w),
    .ok_i   (pw_ok_w),
    .idx_i  (pw_set_i),
    .lock_o (pw_lock_o)
  );

  sess_trial_bank #(.N_SETS(N_KEY_SETS), .LIMIT(TRIAL_LIMIT)) u_key_trials (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (au_try_w),
    .ok_i   (au_ok_w),
    .idx_i  (auth_key_i),
    .lock_o (key_lock_o)
  );

  sess_pw_grant #(.N_SETS(N_PW_SETS)) u_grant (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (rst_pin_i),
    .ok_i    (pw_ok_w),
    .bad_i   (pw_bad_w),
    .set_i   (pw_set_i),
    .wr_i    (pw_write_i),
    .read_o  (pw_read_o),
    .write_o (pw_write_o),
    .set_o   (pw_set_o)
  );

  sess_auth_mode #(.N_KEYS(N_KEY_SETS)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (abandon_w),
    .ok_i     (au_ok_w),
    .bad_i    (au_bad_w),
    .key_i    (auth_key_i),
    .enc_ok_i (enc_ok_w),
    .mode_o   (mode_q),
    .key_o    (key_o)
  );

  assign mode_o = mode_q;

endmodule

// File: rtl/sess_checker.sv
module sess_checker #(
  parameter int N_PW_SETS  = 8,
  parameter int N_KEY_SETS = 4,
  parameter int PW_IW      = 3,
  parameter int KEY_IW     = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rst_pin_i,
  input logic                  mac_fail_i,
  input logic [PW_IW-1:0]      pw_set_i,
  input logic [1:0]            mode_o,
  input logic                  pw_read_o,
  input logic                  pw_write_o,
  input logic [PW_IW-1:0]      pw_set_o,
  input logic [KEY_IW-1:0]     key_o,
  input logic [N_PW_SETS-1:0]  pw_lock_o,
  input logic [N_KEY_SETS-1:0] key_lock_o,
  input logic                  pw_ok_w,
  input logic                  pw_bad_w,
  input logic                  au_ok_w,
  input logic                  au_bad_w
);

  p_write_has_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pw_write_o |-> pw_read_o);

  p_pw_fail_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pw_bad_w |=> (!pw_read_o && !pw_write_o && pw_set_o == '0));

  p_auth_pass_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    au_ok_w |=> mode_o == 2'b01);

  p_auth_fail_std_r5: assert property (@(posedge clk) disable iff (!rst_n)
    au_bad_w |=> (mode_o == 2'b00 && key_o == '0));

  p_enc_needs_auth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_o == 2'b10 && $past(mode_o) == 2'b00));

  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  p_mac_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_fail_i && !rst_pin_i) |=> (mode_o == 2'b00 && $stable(pw_read_o)
                                    && $stable(pw_set_o) && $stable(pw_lock_o)
                                    && $stable(key_lock_o)));

  p_rst_pin_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_i |=> (mode_o == 2'b00 && !pw_read_o && $stable(pw_lock_o)
                   && $stable(key_lock_o)));

  p_lock_needs_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pw_lock_o & ~$past(pw_lock_o))) |-> $past(pw_bad_w));

  p_key_lock_needs_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(key_lock_o & ~$past(key_lock_o))) |-> $past(au_bad_w));

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pw_lock_o & $past(pw_lock_o)) == $past(pw_lock_o)) &&
    ((key_lock_o & $past(key_lock_o)) == $past(key_lock_o)));

  p_locked_no_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pw_ok_w |-> !pw_lock_o[pw_set_i]);

endmodule

bind sec_session_guard sess_checker #(
  .N_PW_SETS (N_PW_SETS),
  .N_KEY_SETS(N_KEY_SETS),
  .PW_IW     (PW_IW),
  .KEY_IW    (KEY_IW)
) u_sess_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_pin_i  (rst_pin_i),
  .mac_fail_i (mac_fail_i),
  .pw_set_i   (pw_set_i),
  .mode_o     (mode_o),
  .pw_read_o  (pw_read_o),
  .pw_write_o (pw_write_o),
  .pw_set_o   (pw_set_o),
  .key_o      (key_o),
  .pw_lock_o  (pw_lock_o),
  .key_lock_o (key_lock_o),
  .pw_ok_w    (pw_ok_w),
  .pw_bad_w   (pw_bad_w),
  .au_ok_w    (au_ok_w),
  .au_bad_w   (au_bad_w)
);

// File: tb/sec_session_guard_tb_top.sv
module sec_session_guard_tb_top;
  localparam int NP = 8;
  localparam int NK = 4;
  localparam int LIM = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin_i = 0, pw_pass_i = 0, pw_fail_i = 0, pw_write_i = 0;
  logic auth_pass_i = 0, auth_fail_i = 0, enc_activate_i = 0, mac_fail_i = 0;
  logic [2:0] pw_set_i = '0;
  logic [1:0] auth_key_i = '0;
  logic [1:0] mode_o;
  logic pw_read_o, pw_write_o;
  logic [2:0] pw_set_o;
  logic [1:0] key_o;
  logic [NP-1:0] pw_lock_o;
  logic [NK-1:0] key_lock_o;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  int m_mode, m_rd, m_wr, m_set, m_key;
  int pcnt[NP];
  int kcnt[NK];

  always #5 clk = ~clk;

  sec_session_guard #(.N_PW_SETS(NP), .N_KEY_SETS(NK), .TRIAL_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_pin_i(rst_pin_i),
    .pw_pass_i(pw_pass_i), .pw_fail_i(pw_fail_i), .pw_set_i(pw_set_i),
    .pw_write_i(pw_write_i), .auth_pass_i(auth_pass_i), .auth_fail_i(auth_fail_i),
    .auth_key_i(auth_key_i), .enc_activate_i(enc_activate_i), .mac_fail_i(mac_fail_i),
    .mode_o(mode_o), .pw_read_o(pw_read_o), .pw_write_o(pw_write_o),
    .pw_set_o(pw_set_o), .key_o(key_o), .pw_lock_o(pw_lock_o), .key_lock_o(key_lock_o)
  );

  function automatic logic [NP-1:0] exp_plock();
    logic [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = (pcnt[i] >= LIM);
    return v;
  endfunction

  function automatic logic [NK-1:0] exp_klock();
    logic [NK-1:0] v;
    for (int i = 0; i < NK; i++) v[i] = (kcnt[i] >= LIM);
    return v;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_rd = 0; m_wr = 0; m_set = 0; m_key = 0;
    for (int i = 0; i < NP; i++) pcnt[i] = 0;
    for (int i = 0; i < NK; i++) kcnt[i] = 0;
  endtask

  task automatic model_step();
    int s, k;
    bit ok;
    if (rst_pin_i) begin
      m_mode = 0; m_rd = 0; m_wr = 0; m_set = 0; m_key = 0;
    end else if (mac_fail_i) begin
      m_mode = 0; m_key = 0;
    end else begin
      if (pw_pass_i || pw_fail_i) begin
        s = int'(pw_set_i);
        ok = pw_pass_i && !pw_fail_i && (pcnt[s] < LIM);
        if (ok) begin
          m_rd = 1; m_wr = int'(pw_write_i); m_set = s; pcnt[s] = 0;
        end else begin
          m_rd = 0; m_wr = 0; m_set = 0;
          if (pcnt[s] < LIM) pcnt[s]++;
        end
      end
      if (auth_pass_i || auth_fail_i) begin
        k = int'(auth_key_i);
        ok = auth_pass_i && !auth_fail_i && (kcnt[k] < LIM);
        if (ok) begin
          m_mode = 1; m_key = k; kcnt[k] = 0;
        end else begin
          m_mode = 0; m_key = 0;
          if (kcnt[k] < LIM) kcnt[k]++;
        end
      end else if (enc_activate_i && m_mode != 0) begin
        m_mode = 2;
      end
    end
  endtask

  task automatic compare(input string rq);
    checks++;
    if (int'(mode_o) != m_mode || int'(pw_read_o) != m_rd || int'(pw_write_o) != m_wr ||
        int'(pw_set_o) != m_set || int'(key_o) != m_key ||
        pw_lock_o != exp_plock() || key_lock_o != exp_klock()) begin
      failures++;
      $display("FAIL %s: got mode=%0d rd=%0d wr=%0d set=%0d key=%0d plock=%b klock=%b exp mode=%0d rd=%0d wr=%0d set=%0d key=%0d plock=%b klock=%b",
               rq, mode_o, pw_read_o, pw_write_o, pw_set_o, key_o, pw_lock_o, key_lock_o,
               m_mode, m_rd, m_wr, m_set, m_key, exp_plock(), exp_klock());
    end
  endtask

  task automatic clear_in();
    rst_pin_i = 0; pw_pass_i = 0; pw_fail_i = 0; pw_write_i = 0;
    auth_pass_i = 0; auth_fail_i = 0; enc_activate_i = 0; mac_fail_i = 0;
  endtask

  // one clock: inputs already set at the falling edge
  task automatic cyc(input string rq);
    @(posedge clk);
    model_step();
    @(negedge clk);
    clear_in();
    compare(rq);
  endtask

  task automatic pw(input bit pass, input bit fail, input int s, input bit w, input string rq);
    pw_pass_i = pass; pw_fail_i = fail; pw_set_i = 3'(s); pw_write_i = w;
    cyc(rq);
  endtask

  task automatic au(input bit pass, input bit fail, input int k, input string rq);
    auth_pass_i = pass; auth_fail_i = fail; auth_key_i = 2'(k);
    cyc(rq);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: got hung run exp finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    clear_in();
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    cyc("R1 idle");

    pw(1, 0, 5, 0, "R2 read password set 5");
    pw(1, 0, 7, 1, "R2 write password set 7");
    pw(1, 0, 2, 0, "R2 latest set replaces");
    pw(0, 1, 2, 0, "R3 password failure clears");

    au(1, 0, 3, "R4 auth pass key 3");
    enc_activate_i = 1; cyc("R6 encryption from auth");
    au(1, 0, 1, "R4 auth pass from encrypted");
    au(0, 1, 1, "R5 auth failure drops");
    enc_activate_i = 1; cyc("R6 activation ignored in standard");

    au(1, 0, 2, "R4 auth again");
    enc_activate_i = 1; cyc("R6 encrypt");
    pw(1, 0, 6, 1, "R2 grant before mac");
    mac_fail_i = 1; pw_pass_i = 1; pw_set_i = 3'd1; auth_pass_i = 1; auth_key_i = 2'd0;
    cyc("R7 mac mismatch abandons cycle");
    mac_fail_i = 1; auth_fail_i = 1; auth_key_i = 2'd3;
    cyc("R7 mac mismatch leaves counters");

    au(1, 0, 1, "R4 auth before pin");
    rst_pin_i = 1; auth_pass_i = 1; auth_key_i = 2'd2; pw_pass_i = 1; pw_set_i = 3'd3;
    cyc("R8 reset pin clears and abandons");

    pw(0, 1, 4, 0, "R9 first failure set 4");
    pw(1, 0, 4, 0, "R9 success clears count");
    pw(0, 1, 4, 0, "R9 failure one");
    pw(0, 1, 4, 0, "R9 failure two locks set 4");
    pw(1, 0, 4, 1, "R10 locked pass grants nothing");
    rst_pin_i = 1; cyc("R8 reset pin keeps locks");
    pw(1, 0, 4, 0, "R10 still locked after pin");
    pw(1, 0, 0, 0, "R2 other set unaffected");

    au(0, 1, 0, "R9 key 0 failure one");
    au(0, 1, 0, "R9 key 0 locked");
    au(1, 0, 0, "R10 locked key pass fails");
    au(1, 0, 3, "R4 highest key set");

    pw(1, 1, 7, 1, "R11 pass and fail together is fail");
    au(1, 1, 1, "R11 auth pass and fail together");
    au(1, 0, 2, "R4 auth key 2");
    enc_activate_i = 1; auth_pass_i = 1; auth_key_i = 2'd1;
    cyc("R11 auth beats activation");

    // R12: nothing changes before the sampling edge
    pw_pass_i = 1; pw_set_i = 3'd3; pw_write_i = 1;
    #1;
    compare("R12 no change before edge");
    cyc("R12 change on edge");

    rst_n = 1'b0;
    #2;
    model_reset();
    compare("R1 power-on clears locks");
    @(negedge clk);
    rst_n = 1'b1;
    pw(1, 0, 4, 0, "R1 set 4 usable after power-on");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule